// File: doc/BRIEF.md
# Root Port Link Bring-Up Sequencer

This block runs the bring-up of one downstream root port and tells the rest of the controller whether the link came up. A single-cycle `start` pulse turns on the port's clocking controls and drives the active-low port reset through a timed pulse. It then forces the presence-detect mapping to "endpoint present" and watches two asynchronous link status lines in turn. The first is the data-link-up indication. The second is the link-active indication.

Each status line has its own wait window, measured in milliseconds and converted to clock cycles from a clock-frequency parameter. A lower frequency value shortens the windows for simulation. If a window closes without the expected status, the port is reset again and the check repeats, up to a fixed number of attempts. When the last attempt fails, the port is shut down in a fixed order: reset is asserted first, and only after that is the reference clock removed. The outcome appears on `pass` or `fail` and stays there until the next start. One instance is used per root port.

Top module: `rp_link_bringup`

## Requirements
- R1: On an accepted `start`, at the next clock edge `refclk_en` and `override_en` go to 1, `clkreq_en` goes to the value of parameter `CLKREQ_EN`, `port_rst_n` is 0, `busy` is 1, and `pass` and `fail` are 0.
- R2: In every attempt, `port_rst_n` is held low for exactly `RST_MS` ms (`CLK_HZ*RST_MS/1000` cycles) and is then driven high.
- R3: `prsnt_map[3:0]` resets to 4'hF ("endpoint absent"). It becomes 4'hE ("endpoint present") when the first reset pulse of a run ends.
- R4: After each reset pulse, the block waits up to `DLUP_MS` ms for data-link-up. Both status inputs pass through a two-flop synchronizer. A status seen on the final cycle of the window is accepted. If the window closes without the status, the attempt fails and no link-active wait is made.
- R5: Once data-link-up is seen, the block waits up to `ACT_MS` ms for link-active. If link-active is seen in that window, the run ends with `pass`=1, `port_rst_n`=1 and `refclk_en`=1. If not, the attempt fails.
- R6: At most `MAX_TRIES` (2) attempts are made. A failed attempt that is not the last starts a new reset pulse, so a run produces one reset pulse for each attempt made.
- R7: After the last attempt fails, `port_rst_n` goes low at least one cycle before `refclk_en` goes low. Then `fail` rises. `clkreq_en` and `override_en` keep their values.
- R8: `pass` and `fail` are never both 1 and are both 0 while `busy` is 1. `busy` falls in the same cycle the outcome appears, and the outcome holds until the next `start`.
- R9: A `start` pulse while `busy` is 1 has no effect on the run: the same number of reset pulses, the same outcome and the same duration.
- R10: After `rst_n` low, the outputs are `refclk_en`=`clkreq_en`=`override_en`=`port_rst_n`=`busy`=`pass`=`fail`=0 and `prsnt_map`=4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to bring the port up |
| dl_up_in | input | 1 | Asynchronous data-link-up status |
| link_act_in | input | 1 | Asynchronous link-active status |
| refclk_en | output | 1 | Reference clock enable for the port |
| clkreq_en | output | 1 | Clock-request enable (when the feature parameter allows it) |
| override_en | output | 1 | Enable override of the port's clock controls |
| port_rst_n | output | 1 | Active-low port reset |
| prsnt_map | output | 4 | Presence-detect mapping code (4'hE present, 4'hF absent) |
| busy | output | 1 | High while a bring-up run is in progress |
| pass | output | 1 | Last run brought the link up |
| fail | output | 1 | Last run gave up and shut the port down |

## Verification
Two events can land in the same cycle: a status line arriving and its wait window running out. The design gives the status priority. The bench provokes this with a partner model that raises data-link-up a set number of cycles after reset release. Delays of DLUP−1 and DLUP cycles place the synchronized status exactly on the last cycle of the window and one cycle past it. The case is judged at the ports. The first delay must produce a pass with one reset pulse. The second must produce a retry, seen as a second reset pulse, before the pass.

// File: rtl/rp_link_pkg.sv
// Shared types for the root port bring-up sequencer.
// Assumes: consumers import the package; no parameters live here.
package rp_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RST_LO   = 3'd1,
        ST_PRSNT    = 3'd2,
        ST_WAIT_DL  = 3'd3,
        ST_WAIT_ACT = 3'd4,
        ST_SHUT_RST = 3'd5,
        ST_SHUT_CLK = 3'd6
    } rp_state_e;

    localparam logic [3:0] PRSNT_EP_HERE = 4'hE;
    localparam logic [3:0] PRSNT_EP_GONE = 4'hF;

endpackage

// File: rtl/rp_sync2.sv
// Two-flop synchronizer, one chain per bit.
// Assumes: each bit is an independent level; no bus coherence is needed.
module rp_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Capture, then re-time, one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[b];
                stab_q <= meta_q;
            end
        end

        assign q_sync[b] = stab_q;
    end
endmodule

// File: rtl/rp_win_timer.sv
// Window timer: counts cycles since the last clear and flags the last
// cycle of a window of `limit` cycles.
// Assumes: limit >= 1 and is stable while not cleared.
module rp_win_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == limit - CNT_W'(1));

    // Count up from zero after each clear; hold at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_TMR_NO_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && last) |=> (last || $past(clr) || !$stable(limit))); // R4
endmodule

// File: rtl/rp_link_bringup.sv
// Root port bring-up sequencer: enables the port clocks, pulses the port
// reset, forces presence, waits for data-link-up and then link-active,
// retries with a fresh reset pulse, and shuts a dead port down with the
// reset asserted before the reference clock is removed.
// Assumes: start is a one-cycle pulse; status inputs are asynchronous.
module rp_link_bringup #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int RST_MS    = 1,
    parameter int DLUP_MS   = 150,
    parameter int ACT_MS    = 200,
    parameter int MAX_TRIES = 2,
    parameter bit CLKREQ_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dl_up_in,
    input  logic       link_act_in,
    output logic       refclk_en,
    output logic       clkreq_en,
    output logic       override_en,
    output logic       port_rst_n,
    output logic [3:0] prsnt_map,
    output logic       busy,
    output logic       pass,
    output logic       fail
);
    import rp_link_pkg::*;

    localparam longint unsigned RST_L = (longint'(CLK_HZ) * RST_MS) / 1000;
    localparam longint unsigned DL_L  = (longint'(CLK_HZ) * DLUP_MS) / 1000;
    localparam longint unsigned ACT_L = (longint'(CLK_HZ) * ACT_MS) / 1000;
    localparam longint unsigned MAX_L = (DL_L > ACT_L) ? ((DL_L > RST_L) ? DL_L : RST_L)
                                                       : ((ACT_L > RST_L) ? ACT_L : RST_L);
    localparam int CNT_W = $clog2(MAX_L + 1);
    localparam logic [CNT_W-1:0] RST_CYC = CNT_W'(RST_L);
    localparam logic [CNT_W-1:0] DL_CYC  = CNT_W'(DL_L);
    localparam logic [CNT_W-1:0] ACT_CYC = CNT_W'(ACT_L);
    localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    rp_state_e        state_q, state_d;
    logic [TRY_W-1:0] try_q;
    logic [1:0]       stat_s;
    logic             dl_s, act_s;
    logic             win_last, win_clr;
    logic [CNT_W-1:0] win_limit;
    logic             last_try, give_up, retry;

    rp_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({link_act_in, dl_up_in}),
        .q_sync  (stat_s)
    );
    assign dl_s  = stat_s[0];
    assign act_s = stat_s[1];

    // Pick the window length for the state being timed.
    always_comb begin
        case (state_q)
            ST_RST_LO:   win_limit = RST_CYC;
            ST_WAIT_DL:  win_limit = DL_CYC;
            ST_WAIT_ACT: win_limit = ACT_CYC;
            default:     win_limit = CNT_W'(1);
        endcase
    end

    assign win_clr = (state_d != state_q);

    rp_win_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .limit (win_limit),
        .last  (win_last)
    );

    assign last_try = (try_q == TRY_W'(MAX_TRIES - 1));
    assign give_up  = ((state_q == ST_WAIT_DL && !dl_s) ||
                       (state_q == ST_WAIT_ACT && !act_s)) && win_last;
    assign retry    = give_up && !last_try;

    // Next-state decision; a status seen on the final window cycle wins.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start) state_d = ST_RST_LO;
            ST_RST_LO:   if (win_last) state_d = ST_PRSNT;
            ST_PRSNT:    state_d = ST_WAIT_DL;
            ST_WAIT_DL:  if (dl_s) state_d = ST_WAIT_ACT;
                         else if (win_last) state_d = last_try ? ST_SHUT_RST : ST_RST_LO;
            ST_WAIT_ACT: if (act_s) state_d = ST_IDLE;
                         else if (win_last) state_d = last_try ? ST_SHUT_RST : ST_RST_LO;
            ST_SHUT_RST: state_d = ST_SHUT_CLK;
            ST_SHUT_CLK: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Attempt counter: cleared on start, advanced on each retry.
    always_ff @(posedge clk) begin
        if (!rst_n)                         try_q <= '0;
        else if (state_q == ST_IDLE && start) try_q <= '0;
        else if (retry)                     try_q <= try_q + TRY_W'(1);
    end

    // Port clock controls: on at start, reference clock off in shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refclk_en   <= 1'b0;
            clkreq_en   <= 1'b0;
            override_en <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            refclk_en   <= 1'b1;
            clkreq_en   <= CLKREQ_EN;
            override_en <= 1'b1;
        end else if (state_q == ST_SHUT_CLK) begin
            refclk_en   <= 1'b0;
        end
    end

    // Port reset: low during pulses and shutdown, released after a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             port_rst_n <= 1'b0;
        else if (state_d == ST_RST_LO || state_d == ST_SHUT_RST) port_rst_n <= 1'b0;
        else if (state_d == ST_PRSNT)                           port_rst_n <= 1'b1;
    end

    // Presence mapping: forced to present once the first pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                   prsnt_map <= PRSNT_EP_GONE;
        else if (state_d == ST_PRSNT) prsnt_map <= PRSNT_EP_HERE;
    end

    // Run status and held outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pass <= 1'b0;
            fail <= 1'b0;
        end else begin
            busy <= (state_d != ST_IDLE);
            if (state_q == ST_IDLE && start) begin
                pass <= 1'b0;
                fail <= 1'b0;
            end else if (state_q == ST_WAIT_ACT && act_s) begin
                pass <= 1'b1;
            end else if (state_q == ST_SHUT_CLK) begin
                fail <= 1'b1;
            end
        end
    end

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R8
    AST_BUSY_HIDES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!pass && !fail)); // R8
    AST_RST_BEFORE_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refclk_en) |-> (!port_rst_n && $past(!port_rst_n))); // R7
    AST_CLK_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_rst_n) |-> (refclk_en && override_en)); // R1
    AST_PRSNT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_rst_n) |=> (prsnt_map == PRSNT_EP_HERE)); // R3
    AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (try_q < TRY_W'(MAX_TRIES - 1))); // R6
endmodule

// File: tb/rp_link_bringup_tb.sv
module rp_link_bringup_tb;
    localparam int HZ   = 10_000;
    localparam int RC   = HZ * 1 / 1000;    // reset pulse cycles
    localparam int DC   = HZ * 150 / 1000;  // data-link-up window
    localparam int AC   = HZ * 200 / 1000;  // link-active window
    localparam int NEVER = 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dl_up_in = 1'b0;
    logic link_act_in = 1'b0;
    logic refclk_en, clkreq_en, override_en, port_rst_n, busy, pass, fail;
    logic [3:0] prsnt_map;

    always #4 clk = ~clk;

    rp_link_bringup #(.CLK_HZ(HZ), .RST_MS(1), .DLUP_MS(150), .ACT_MS(200),
                      .MAX_TRIES(2), .CLKREQ_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dl_up_in(dl_up_in),
        .link_act_in(link_act_in), .refclk_en(refclk_en), .clkreq_en(clkreq_en),
        .override_en(override_en), .port_rst_n(port_rst_n), .prsnt_map(prsnt_map),
        .busy(busy), .pass(pass), .fail(fail)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-attempt plan of the link partner model.
    bit p_dl_ok [2];
    int p_dl_dly [2];
    bit p_act_ok [2];
    int p_act_dly [2];

    int rises = 0;
    int busy_cyc = 0;
    int low_run = 0;
    int since = 0;
    bit prev_rst = 1'b0;
    bit prev_clk_en = 1'b0;

    // Link partner model and port monitor, sampled away from the edge.
    always @(negedge clk) begin
        int idx;
        if (busy) busy_cyc++;
        if (prev_clk_en && !refclk_en)
            check(!prev_rst, "R7 reset low before clock off", prev_rst, 0);
        if (port_rst_n && !prev_rst && rst_n) begin
            rises++;
            check(low_run == RC, "R2 reset pulse width", low_run, RC);
        end
        if (!port_rst_n && busy) low_run++;
        else low_run = 0;
        if (!port_rst_n) begin
            since = 0;
            dl_up_in = 1'b0;
            link_act_in = 1'b0;
        end else begin
            since++;
            idx = (rises >= 2) ? 1 : 0;
            dl_up_in = p_dl_ok[idx] && (since >= p_dl_dly[idx]);
            link_act_in = dl_up_in && p_act_ok[idx] && (since >= p_dl_dly[idx] + p_act_dly[idx]);
        end
        prev_rst = port_rst_n;
        prev_clk_en = refclk_en;
    end

    function automatic bit attempt_ok(bit dok, int dd, bit aok, int ad);
        int e = (dd < 1) ? 1 : dd;
        return dok && (e <= DC - 1) && aok && (ad <= AC);
    endfunction

    task automatic run_case(input string nm,
                            input bit d0, input int dd0, input bit a0, input int ad0,
                            input bit d1, input int dd1, input bit a1, input int ad1,
                            input bit poke, output int cyc_busy);
        bit ok0, ok1, exp_pass;
        int cyc;
        p_dl_ok[0] = d0; p_dl_dly[0] = dd0; p_act_ok[0] = a0; p_act_dly[0] = ad0;
        p_dl_ok[1] = d1; p_dl_dly[1] = dd1; p_act_ok[1] = a1; p_act_dly[1] = ad1;
        ok0 = attempt_ok(d0, dd0, a0, ad0);
        ok1 = attempt_ok(d1, dd1, a1, ad1);
        exp_pass = ok0 || ok1;
        @(negedge clk);
        rises = 0;
        busy_cyc = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !pass && !fail, {"R1 run begins ", nm}, {busy, pass, fail}, 3'b100);
        check(refclk_en && override_en && clkreq_en && !port_rst_n, {"R1 port enables ", nm},
              {refclk_en, override_en, clkreq_en, port_rst_n}, 4'b1110);
        cyc = 0;
        while (busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = (poke && (cyc == 50 || cyc == 2000));
        end
        start = 1'b0;
        cyc_busy = busy_cyc;
        check(!busy && pass == exp_pass && fail == !exp_pass, {"R5 R6 outcome ", nm},
              {busy, pass, fail}, {1'b0, exp_pass, !exp_pass});
        check(rises == (ok0 ? 1 : 2), {"R6 reset pulses ", nm}, rises, ok0 ? 1 : 2);
        check(prsnt_map == 4'hE, {"R3 presence code ", nm}, prsnt_map, 4'hE);
        if (exp_pass)
            check(refclk_en && port_rst_n, {"R5 port left running ", nm},
                  {refclk_en, port_rst_n}, 2'b11);
        else
            check(!refclk_en && !port_rst_n && clkreq_en && override_en,
                  {"R7 shutdown state ", nm},
                  {refclk_en, port_rst_n, clkreq_en, override_en}, 4'b0011);
        repeat (5) @(negedge clk);
        check(pass == exp_pass && fail == !exp_pass && !busy, {"R8 outcome holds ", nm},
              {pass, fail}, {exp_pass, !exp_pass});
    endtask

    task automatic run_all();
        int bc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!refclk_en && !clkreq_en && !override_en && !port_rst_n && !busy && !pass && !fail,
              "R10 reset outputs",
              {refclk_en, clkreq_en, override_en, port_rst_n, busy, pass, fail}, 0);
        check(prsnt_map == 4'hF, "R10 R3 reset presence code", prsnt_map, 4'hF);

        run_case("fast link", 1, 5, 1, 5, 1, 5, 1, 5, 0, bc);
        run_case("R4 dl on last window cycle", 1, DC - 1, 1, 3, 0, 0, 0, 0, 0, bc);
        run_case("R4 dl one cycle late", 1, DC, 1, 3, 1, 4, 1, 4, 0, bc);
        run_case("R9 dead link with start pokes", 0, 0, 0, 0, 0, 0, 0, 0, 1, bc);
        check(bc >= 2 * (RC + DC) && bc <= 2 * (RC + DC) + 10, "R4 R9 dead run length",
              bc, 2 * (RC + DC) + 4);
        run_case("R5 active never", 1, 7, 0, 0, 1, 9, 0, 0, 0, bc);
        check(bc > 2 * (RC + AC) && bc <= 2 * (RC + AC + 30), "R5 active timeout length",
              bc, 2 * (RC + AC));
        run_case("R6 retry recovers", 1, 3, 0, 0, 1, 6, 1, 8, 0, bc);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 10; i++) begin
            bit d0 = ($urandom % 4) != 0;
            int dd0 = 1 + $urandom % (DC / 2);
            bit a0 = ($urandom % 4) != 0;
            int ad0 = $urandom % (AC / 2);
            bit d1 = ($urandom % 4) != 0;
            int dd1 = 1 + $urandom % (DC / 2);
            bit a1 = ($urandom % 4) != 0;
            int ad1 = $urandom % (AC / 2);
            run_case($sformatf("random %0d", i), d0, dd0, a0, ad0, d1, dd1, a1, ad1, 0, bc);
        end
    endtask

    initial begin
        bit wd = 1'b0;
        p_dl_ok[0] = 0; p_dl_ok[1] = 0; p_act_ok[0] = 0; p_act_ok[1] = 0;
        p_dl_dly[0] = NEVER; p_dl_dly[1] = NEVER; p_act_dly[0] = 0; p_act_dly[1] = 0;
        fork
            run_all();
            begin
                repeat (190_000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule